// File: doc/BRIEF.md
# Programmable Bit-Rate Clock and Synchronous Data Port

This block turns a crystal reference clock into a programmable bit-rate clock for a one-bit serial data port. The rate comes from a 6-bit divider and a 3-bit power-of-two scale, so one bit period is `divider * 2^(7 - scale)` reference cycles. That clock is driven out on the data-clock pin with a 50 % duty cycle. Configuration arrives as register writes, each carrying a 7-bit address and an 8-bit data byte.

With the synchronous mode bit clear, the data-clock pin is held low and data passes straight through the port. In transmit mode the user's line goes to the modulator output, and in receive mode the recovered data goes to the data pin. With the bit set, the block is the clock master:
- In transmit mode it samples the user's line on each rising data-clock edge and holds that bit for the modulator.
- In receive mode it updates the data pin on each rising edge, so the user can sample it on the falling edge.

The block drives the data pin only in receive mode. In transmit mode the pin is released to the user.

Top module: `bitclk_port`

## Requirements
- R1: During reset and right after it, `dclk` is 0, `mod_bit` is 0, synchronous mode is off, the divider is 1 and the scale is 0. Enabling synchronous mode with no other write gives high and low phases of 64 reference cycles each.
- R2: A write to address 7'd0 sets synchronous mode from data bit 3. A write to address 7'd6 sets scale bit 2 from data bit 0. A write to address 7'd7 sets scale bits 1..0 from data bits 7..6 and the divider from data bits 5..0. Writes to any other address change nothing.
- R3: With synchronous mode on, `dclk` stays high for H reference cycles and then low for H reference cycles, where H = divider * 2^(6 - scale). The full period is therefore divider * 2^(7 - scale).
- R4: A divider value of 0 behaves as 1. A scale value of 7 behaves as 6.
- R5: A new divider or scale takes effect only at the next falling edge of `dclk`. A low phase and the high phase after it always use the same value.
- R6: With synchronous mode off, `dclk` is low from the cycle after the mode bit clears. `mod_bit` follows `usr_data_in` combinationally in transmit mode, and `data_out` follows `rx_data` combinationally in receive mode.
- R7: With synchronous mode on in transmit mode, `mod_bit` takes the value `usr_data_in` had at the reference edge where `dclk` rises. It holds that value until the next rise.
- R8: With synchronous mode on in receive mode, `data_out` takes the value `rx_data` had at the reference edge where `dclk` rises. It holds that value until the next rise.
- R9: `data_oe` is 0 whenever `tx_mode` is 1 and is 1 whenever `tx_mode` is 0. In receive mode `mod_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address |
| cfg_wdata | input | 8 | Register write data |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| usr_data_in | input | 1 | Value on the data pin as driven by the user |
| rx_data | input | 1 | Recovered data from the demodulator |
| dclk | output | 1 | Bit-rate data clock pin |
| data_out | output | 1 | Value driven on the data pin in receive mode |
| data_oe | output | 1 | Output enable for the data pin |
| mod_bit | output | 1 | Transmit bit sent to the modulator |

## Verification
The assertions assume that register writes are single-cycle strobes with a stable address and data. They also assume that `tx_mode` is not switched while a bit is being captured.

The stimulus drives every input at the falling edge of the reference clock. It changes the configuration only while synchronous mode is off, except in the boundary test for R5. It changes user and receive data only after an observed falling edge of `dclk`, which keeps every sample well inside a stable phase.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  parameter int ADDR_W  = 7;
  parameter int DATA_W  = 8;
  parameter int DIV_W   = 6;
  parameter int SCL_W   = 3;
  parameter int SCL_MAX = 6;
  localparam int HALF_W = DIV_W + SCL_MAX;
endpackage

// File: rtl/bitclk_rst_sync.sv
module bitclk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/bitclk_cfg.sv
module bitclk_cfg
  import bitclk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] A_CTRL  = 7'd0,
  parameter logic [ADDR_W-1:0] A_RATEH = 7'd6,
  parameter logic [ADDR_W-1:0] A_RATEL = 7'd7,
  parameter int SYNC_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sync_en,
  output logic [DIV_W-1:0]  div_val,
  output logic [SCL_W-1:0]  scl_val
);
  localparam int SCL_LO_W = SCL_W - 1;

  logic             sync_q, sync_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [SCL_W-1:0] scl_q, scl_d;
  logic             wr_ctrl, wr_rateh, wr_ratel;

  always_comb begin
    wr_ctrl  = we && (addr == A_CTRL);
    wr_rateh = we && (addr == A_RATEH);
    wr_ratel = we && (addr == A_RATEL);
    sync_d = sync_q;
    div_d  = div_q;
    scl_d  = scl_q;
    if (wr_ctrl)  sync_d = wdata[SYNC_BIT];
    if (wr_rateh) scl_d[SCL_W-1] = wdata[0];
    if (wr_ratel) begin
      scl_d[SCL_LO_W-1:0] = wdata[DATA_W-1 -: SCL_LO_W];
      div_d = wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      div_q  <= DIV_W'(1);
      scl_q  <= '0;
    end else begin
      sync_q <= sync_d;
      div_q  <= div_d;
      scl_q  <= scl_d;
    end
  end

  assign sync_en = sync_q;
  assign div_val = div_q;
  assign scl_val = scl_q;

  // R2: divider follows a write to the low rate register
  a_r2_div_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_RATEL) |=> (div_q == $past(wdata[DIV_W-1:0])));
  // R2: writes elsewhere leave the mode bit alone
  a_r2_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_CTRL) |=> $stable(sync_q));
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic [SCL_W-1:0] scl_val,
  output logic             dclk,
  output logic             rise
);
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [HALF_W-1:0] cfg_half;
  logic              dclk_q, dclk_d;
  logic              wrap;
  logic [DIV_W-1:0]  eff_div;
  logic [SCL_W-1:0]  eff_scl;
  logic [SCL_W-1:0]  shift_amt;

  always_comb begin
    eff_div   = (div_val == '0) ? DIV_W'(1) : div_val;
    eff_scl   = (int'(scl_val) > SCL_MAX) ? SCL_W'(SCL_MAX) : scl_val;
    shift_amt = SCL_W'(SCL_MAX) - eff_scl;
    cfg_half  = HALF_W'(eff_div) << shift_amt;
  end

  always_comb begin
    wrap   = (cnt_q == half_q - HALF_W'(1));
    cnt_d  = cnt_q;
    dclk_d = dclk_q;
    half_d = half_q;
    if (!sync_en) begin
      cnt_d  = '0;
      dclk_d = 1'b0;
      half_d = cfg_half;
    end else if (wrap) begin
      cnt_d  = '0;
      dclk_d = ~dclk_q;
      if (dclk_q) half_d = cfg_half;
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
      half_q <= HALF_W'(1) << SCL_MAX;
    end else begin
      cnt_q  <= cnt_d;
      dclk_q <= dclk_d;
      half_q <= half_d;
    end
  end

  assign dclk = dclk_q;
  assign rise = sync_en && !dclk_q && wrap;

  // R6: clock pin parks low once synchronous mode is off
  a_r6_clk_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> !dclk_q);
  // R3: phase counter never passes the active half period
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en |-> (cnt_q < half_q));
  // R5: active half period changes only when a high phase ends
  a_r5_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && dclk_q) |=> ($stable(half_q) || !dclk_q));
  // R4: half period is never zero
  a_r4_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    half_q != '0);
endmodule

// File: rtl/bitclk_dport.sv
module bitclk_dport (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_en,
  input  logic rise,
  input  logic tx_mode,
  input  logic usr_data_in,
  input  logic rx_data,
  output logic data_out,
  output logic data_oe,
  output logic mod_bit
);
  logic tx_smp_q, tx_smp_d;
  logic rx_hold_q, rx_hold_d;

  always_comb begin
    tx_smp_d  = tx_smp_q;
    rx_hold_d = rx_hold_q;
    if (rise) begin
      tx_smp_d  = usr_data_in;
      rx_hold_d = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_smp_q  <= 1'b0;
      rx_hold_q <= 1'b0;
    end else begin
      tx_smp_q  <= tx_smp_d;
      rx_hold_q <= rx_hold_d;
    end
  end

  always_comb begin
    data_oe  = !tx_mode;
    data_out = tx_mode ? 1'b0 : (sync_en ? rx_hold_q : rx_data);
    mod_bit  = tx_mode ? (sync_en ? tx_smp_q : usr_data_in) : 1'b0;
  end

  // R7: transmit sample holds between rising clock edges
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(tx_smp_q));
  // R8: receive hold register takes the recovered bit at a rise
  a_r8_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (rx_hold_q == $past(rx_data)));
endmodule

// File: rtl/bitclk_port.sv
module bitclk_port
  import bitclk_pkg::*;
(
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              tx_mode,
  input  logic              usr_data_in,
  input  logic              rx_data,
  output logic              dclk,
  output logic              data_out,
  output logic              data_oe,
  output logic              mod_bit
);
  logic             srst_n;
  logic             sync_en;
  logic [DIV_W-1:0] div_val;
  logic [SCL_W-1:0] scl_val;
  logic             rise;

  bitclk_rst_sync u_rst (
    .clk(clk_ref), .arst_n(rst_n), .srst_n(srst_n)
  );

  bitclk_cfg u_cfg (
    .clk(clk_ref), .rst_n(srst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .sync_en(sync_en), .div_val(div_val), .scl_val(scl_val)
  );

  bitclk_gen u_gen (
    .clk(clk_ref), .rst_n(srst_n), .sync_en(sync_en), .div_val(div_val),
    .scl_val(scl_val), .dclk(dclk), .rise(rise)
  );

  bitclk_dport u_dport (
    .clk(clk_ref), .rst_n(srst_n), .sync_en(sync_en), .rise(rise),
    .tx_mode(tx_mode), .usr_data_in(usr_data_in), .rx_data(rx_data),
    .data_out(data_out), .data_oe(data_oe), .mod_bit(mod_bit)
  );
endmodule

// File: tb/bitclk_port_bench.sv
module bitclk_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [6:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       tx_mode, usr_data_in, rx_data;
  logic       dclk, data_out, data_oe, mod_bit;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  bitclk_port u_bitclk_port (
    .clk_ref(clk_ref), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_mode(tx_mode), .usr_data_in(usr_data_in),
    .rx_data(rx_data), .dclk(dclk), .data_out(data_out), .data_oe(data_oe),
    .mod_bit(mod_bit)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  always @(posedge clk_ref) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk_ref);
    cfg_we = 1'b0;
    @(negedge clk_ref);
  endtask

  task automatic measure(output int hi, output int lo);
    while (dclk !== 1'b0) @(negedge clk_ref);
    while (dclk === 1'b0) @(negedge clk_ref);
    hi = 0;
    while (dclk === 1'b1) begin hi++; @(negedge clk_ref); end
    lo = 0;
    while (dclk === 1'b0) begin lo++; @(negedge clk_ref); end
  endtask

  task automatic wait_fall();
    while (dclk !== 1'b1) @(negedge clk_ref);
    while (dclk === 1'b1) @(negedge clk_ref);
  endtask

  task automatic wait_rise();
    while (dclk === 1'b1) @(negedge clk_ref);
    while (dclk === 1'b0) @(negedge clk_ref);
  endtask

  initial begin
    int hi, lo, ed, es, exp_h;
    int divs [4] = '{0, 1, 3, 7};
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tx_mode = 1'b0; usr_data_in = 1'b0; rx_data = 1'b0;
    repeat (3) @(negedge clk_ref);
    check("R1 dclk in reset", dclk, 0);
    check("R1 mod_bit in reset", mod_bit, 0);
    check("R9 oe in rx", data_oe, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_ref);
    repeat (20) begin
      check("R1 dclk after reset", dclk, 0);
      @(negedge clk_ref);
    end
    // R1: defaults give half period 64
    wr(7'd0, 8'h08);
    measure(hi, lo);
    check("R1 default high", hi, 64);
    check("R1 default low", lo, 64);

    // R2: unmapped address leaves rate and mode untouched
    wr(7'd5, 8'hFF);
    wr(7'd1, 8'h00);
    measure(hi, lo);
    check("R2 ignored write high", hi, 64);
    check("R2 ignored write low", lo, 64);

    // R3/R4/R2: sweep divider and scale
    foreach (divs[i]) begin
      for (int s = 0; s < 8; s++) begin
        wr(7'd0, 8'h00);
        wr(7'd6, 8'(s >> 2));
        wr(7'd7, 8'(((s & 3) << 6) | divs[i]));
        wr(7'd0, 8'hF7 | 8'h08);
        ed = (divs[i] == 0) ? 1 : divs[i];
        es = (s > 6) ? 6 : s;
        exp_h = ed * (1 << (6 - es));
        measure(hi, lo);
        check((s == 7 || divs[i] == 0) ? "R4 clamp high" : "R3 high", hi, exp_h);
        check((s == 7 || divs[i] == 0) ? "R4 clamp low" : "R3 low", lo, exp_h);
      end
    end

    // R5: change during a low phase applies from the next low phase
    wr(7'd0, 8'h00);
    wr(7'd6, 8'h00);
    wr(7'd7, 8'h84);            // scale 6 (bit2=0 is overwritten below), div 4
    wr(7'd6, 8'h01);            // scale = 3'b110 -> half = 4
    wr(7'd0, 8'h08);
    measure(hi, lo);
    check("R5 base high", hi, 4);
    wait_fall();
    wr(7'd7, 8'h89);            // div 9, scale 6
    hi = 0;
    while (dclk === 1'b0) @(negedge clk_ref);
    while (dclk === 1'b1) begin hi++; @(negedge clk_ref); end
    check("R5 old high", hi, 4);
    lo = 0;
    while (dclk === 1'b0) begin lo++; @(negedge clk_ref); end
    check("R5 new low", lo, 9);

    // R6: transparent mode
    wr(7'd0, 8'h00);
    tx_mode = 1'b1;
    for (int k = 0; k < 6; k++) begin
      usr_data_in = k[0];
      #1;
      check("R6 tx transparent", mod_bit, k[0]);
      check("R6 dclk low", dclk, 0);
      check("R9 oe in tx", data_oe, 0);
      @(negedge clk_ref);
    end
    tx_mode = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rx_data = ~k[0];
      #1;
      check("R6 rx transparent", data_out, ~k[0] & 1);
      check("R9 mod_bit in rx", mod_bit, 0);
      @(negedge clk_ref);
    end

    // R7: synchronous transmit, half = 3
    wr(7'd7, 8'h83);
    wr(7'd0, 8'h08);
    tx_mode = 1'b1;
    for (int k = 0; k < 8; k++) begin
      logic b;
      b = (k * 5 + 1) % 3 == 0;
      wait_fall();
      usr_data_in = b;
      wait_rise();
      check("R7 tx sample", mod_bit, b);
      usr_data_in = ~b;
      @(negedge clk_ref);
      check("R7 tx hold", mod_bit, b);
    end

    // R8: synchronous receive
    tx_mode = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic b;
      b = k[1] ^ k[0];
      wait_fall();
      rx_data = b;
      wait_rise();
      check("R8 rx present", data_out, b);
      rx_data = ~b;
      @(negedge clk_ref);
      check("R8 rx hold", data_out, b);
      check("R9 oe rx sync", data_oe, 1);
    end

    // R6: clearing the mode bit parks the clock
    wr(7'd0, 8'h00);
    check("R6 dclk parked", dclk, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule